// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Select Resolver

This block sits beside the pads of a clock generator whose configuration pins are shared with clock outputs. While power-on reset is asserted, the shared pads act as inputs and the block records their levels into a strap latch. When reset is released, the pads are switched over to drive clocks, and the recorded levels stay fixed until the next power-on reset.

Once out of reset, the block works out the operating configuration on every clock. A four-bit frequency-row code is taken from the latched straps or from a software configuration byte, depending on an override bit in that byte. The spread type, spread enable and global tristate request come from other bits of the same byte. The memory-frequency select, the desktop/mobile mode and the peripheral-clock select come from the straps. All results are registered. A one-cycle strobe marks each new frequency code. The synthesizers that read the code are outside this block.

Top module: `strap_freq_ctl`

## Requirements
- R1: While `porN` is sampled low, `strapPins` is captured into the strap latch on every clock edge, and `padOutEn` is all zeros from the edge after the first low sample.
- R2: From the first clock edge that samples `porN` high, `padOutEn` is all ones.
- R3: The strap latch keeps the pin levels seen at the last edge with `porN` low. Pin activity after reset release changes no output.
- R4: With `cfgByte[3]` = 0, `freqCode` = {strap bit 3, strap bits 2:0}. Strap bit 3 is the memory select and bits 2:0 are the frequency straps.
- R5: With `cfgByte[3]` = 1, `freqCode` = {`cfgByte[2]`, `cfgByte[6]`, `cfgByte[5]`, `cfgByte[4]`}, most significant bit first.
- R6: `spreadDown` follows `cfgByte[7]` (1 = down spread 0 to -0.5 %, 0 = centre spread ±0.25 %). `spreadEn` follows `cfgByte[1]` and `tristateAll` follows `cfgByte[0]`, each one cycle later.
- R7: `memSel` = strap bit 3. `periph24` = strap bit 4 (0 selects the 14.318 MHz peripheral clock, 1 selects 24 MHz). `desktopMode` = strap bit 5 (0 = mobile).
- R8: `codeValid` is high for exactly one cycle in the cycle that `freqCode` takes a new value, including the first resolved code after reset release. It stays low while the code is unchanged.
- R9: While `porN` is low, every resolved output is zero from the edge after the low sample. Outputs are first resolved at the second edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, sampled on `clk` |
| strapPins | input | 6 | Shared pad input levels: [2:0] frequency straps, [3] memory select, [4] peripheral select, [5] desktop mode |
| cfgByte | input | 8 | Configuration byte from the register file |
| padOutEn | output | 6 | Pad direction per shared pin, 1 = drive clock |
| freqCode | output | 4 | Resolved frequency-row code |
| codeValid | output | 1 | One-cycle strobe on a new code |
| spreadDown | output | 1 | Spread type, 1 = down spread |
| spreadEn | output | 1 | Spread spectrum enable |
| tristateAll | output | 1 | Request to float all clock outputs |
| memSel | output | 1 | Latched memory-frequency select |
| desktopMode | output | 1 | Latched mode, 1 = desktop, 0 = mobile |
| periph24 | output | 1 | Latched peripheral select, 1 = 24 MHz |

## Verification
The bench changes the pins in the last reset cycle, so a latch that captured only the first reset sample would report the wrong straps. It also toggles the pins after release, so a latch left open would change `memSel` or `freqCode`. It sweeps all sixteen override codes and holds some codes for several cycles. A bit-order slip in the override mapping would show up as a wrong code. A strobe tied to "any cycle" or to the override bit instead of the code value would pulse at the wrong time. A second power-on reset with different straps checks that re-capture works and that the first resolved code raises the strobe again.

// File: rtl/strap_pkg.sv
package strap_pkg;
  parameter int STRAP_W = 6;
  parameter int CODE_W  = 4;
  parameter int CFG_W   = 8;

  localparam int MEM_BIT    = 3;
  localparam int PERIPH_BIT = 4;
  localparam int DESK_BIT   = 5;
  localparam int OVR_BIT    = 3;
  localparam int SPDN_BIT   = 7;
  localparam int SPEN_BIT   = 1;
  localparam int TRI_BIT    = 0;

  typedef struct packed {
    logic capture;
    logic live;
  } ctlStrobe_t;

  function automatic int swPos(input int idx);
    case (idx)
      3:       return 2;
      2:       return 6;
      1:       return 5;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/strap_ctl.sv
module strap_ctl
  import strap_pkg::*;
#(
  parameter int PIN_W = STRAP_W
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [PIN_W-1:0] strapPins,
  output logic [PIN_W-1:0] strapQ,
  output logic [PIN_W-1:0] padOutEn,
  output ctlStrobe_t       strobe
);
  logic liveQ;

  always_ff @(posedge clk) begin
    if (!porN) strapQ <= strapPins;
  end

  always_ff @(posedge clk) begin
    liveQ <= porN;
  end

  genvar gi;
  generate
    for (gi = 0; gi < PIN_W; gi++) begin : g_dir
      logic dirQ;
      always_ff @(posedge clk) dirQ <= porN;
      assign padOutEn[gi] = dirQ;
    end
  endgenerate

  always_comb begin
    strobe.capture = !porN;
    strobe.live    = liveQ && porN;
  end
endmodule

// File: rtl/freq_sel_dp.sv
module freq_sel_dp
  import strap_pkg::*;
#(
  parameter int PIN_W = STRAP_W,
  parameter int CW    = CODE_W,
  parameter int BW    = CFG_W
) (
  input  logic             clk,
  input  ctlStrobe_t       strobe,
  input  logic [PIN_W-1:0] strapQ,
  input  logic [BW-1:0]    cfgByte,
  output logic [CW-1:0]    freqCode,
  output logic             codeValid,
  output logic             spreadDown,
  output logic             spreadEn,
  output logic             tristateAll,
  output logic             memSel,
  output logic             desktopMode,
  output logic             periph24
);
  localparam int FS_W = CW - 1;

  logic [CW-1:0] swCode, hwCode, effCode;
  logic          haveQ;

  genvar gi;
  generate
    for (gi = 0; gi < CW; gi++) begin : g_sw
      assign swCode[gi] = cfgByte[swPos(gi)];
    end
    for (gi = 0; gi < FS_W; gi++) begin : g_hw
      assign hwCode[gi] = strapQ[gi];
    end
  endgenerate
  assign hwCode[CW-1] = strapQ[MEM_BIT];

  assign effCode = cfgByte[OVR_BIT] ? swCode : hwCode;

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      freqCode    <= '0;
      codeValid   <= 1'b0;
      haveQ       <= 1'b0;
      spreadDown  <= 1'b0;
      spreadEn    <= 1'b0;
      tristateAll <= 1'b0;
      memSel      <= 1'b0;
      desktopMode <= 1'b0;
      periph24    <= 1'b0;
    end else if (strobe.live) begin
      freqCode    <= effCode;
      codeValid   <= !haveQ || (effCode != freqCode);
      haveQ       <= 1'b1;
      spreadDown  <= cfgByte[SPDN_BIT];
      spreadEn    <= cfgByte[SPEN_BIT];
      tristateAll <= cfgByte[TRI_BIT];
      memSel      <= strapQ[MEM_BIT];
      desktopMode <= strapQ[DESK_BIT];
      periph24    <= strapQ[PERIPH_BIT];
    end else begin
      codeValid   <= 1'b0;
    end
  end
endmodule

// File: rtl/strap_freq_ctl.sv
module strap_freq_ctl
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               porN,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [CFG_W-1:0]   cfgByte,
  output logic [STRAP_W-1:0] padOutEn,
  output logic [CODE_W-1:0]  freqCode,
  output logic               codeValid,
  output logic               spreadDown,
  output logic               spreadEn,
  output logic               tristateAll,
  output logic               memSel,
  output logic               desktopMode,
  output logic               periph24
);
  logic [STRAP_W-1:0] strapQ;
  ctlStrobe_t         strobe;

  strap_ctl #(.PIN_W(STRAP_W)) u_ctl (
    .clk(clk), .porN(porN), .strapPins(strapPins),
    .strapQ(strapQ), .padOutEn(padOutEn), .strobe(strobe)
  );

  freq_sel_dp #(.PIN_W(STRAP_W), .CW(CODE_W), .BW(CFG_W)) u_dp (
    .clk(clk), .strobe(strobe), .strapQ(strapQ), .cfgByte(cfgByte),
    .freqCode(freqCode), .codeValid(codeValid), .spreadDown(spreadDown),
    .spreadEn(spreadEn), .tristateAll(tristateAll), .memSel(memSel),
    .desktopMode(desktopMode), .periph24(periph24)
  );
endmodule

// File: rtl/strap_freq_chk.sv
module strap_freq_chk
  import strap_pkg::*;
(
  input logic               clk,
  input logic               porN,
  input logic [2:0]         spreadCfg,
  input logic [STRAP_W-1:0] padOutEn,
  input logic [CODE_W-1:0]  freqCode,
  input logic               codeValid,
  input logic               spreadDown,
  input logic               spreadEn,
  input logic               tristateAll,
  input logic               memSel,
  input logic               desktopMode,
  input logic               periph24
);
  AST_PADS_INPUT_IN_POR: assert property (@(posedge clk) !porN |=> (padOutEn == '0)); // R1
  AST_PADS_DRIVE_AFTER_POR: assert property (@(posedge clk) (porN && $past(porN)) |-> (&padOutEn)); // R2
  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!porN)
    ($past(porN) && $past(porN, 2) && $past(porN, 3)) |->
      ($stable(memSel) && $stable(desktopMode) && $stable(periph24))); // R3
  AST_CFG_BITS_FOLLOW: assert property (@(posedge clk) disable iff (!porN)
    ($past(porN) && $past(porN, 2)) |->
      ({spreadDown, spreadEn, tristateAll} == $past(spreadCfg))); // R6
  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!porN)
    ($past(porN) && $past(porN, 2) && $past(porN, 3)) |->
      (codeValid == (freqCode != $past(freqCode)))); // R8
  AST_OUTPUTS_QUIET_IN_POR: assert property (@(posedge clk) !porN |=>
    (freqCode == '0 && !codeValid && !memSel && !periph24)); // R9
endmodule

bind strap_freq_ctl strap_freq_chk u_chk (
  .clk(clk), .porN(porN),
  .spreadCfg({cfgByte[SPDN_BIT], cfgByte[SPEN_BIT], cfgByte[TRI_BIT]}),
  .padOutEn(padOutEn), .freqCode(freqCode), .codeValid(codeValid),
  .spreadDown(spreadDown), .spreadEn(spreadEn), .tristateAll(tristateAll),
  .memSel(memSel), .desktopMode(desktopMode), .periph24(periph24)
);

// File: tb/sim_strap_freq_ctl.sv
`timescale 1ns/1ps
module sim_strap_freq_ctl;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [5:0] strapPins = 6'h15;
  logic [7:0] cfgByte = 8'h00;
  logic [5:0] padOutEn;
  logic [3:0] freqCode;
  logic codeValid, spreadDown, spreadEn, tristateAll, memSel, desktopMode, periph24;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strap_freq_ctl u0 (
    .clk(clk), .porN(porN), .strapPins(strapPins), .cfgByte(cfgByte),
    .padOutEn(padOutEn), .freqCode(freqCode), .codeValid(codeValid),
    .spreadDown(spreadDown), .spreadEn(spreadEn), .tristateAll(tristateAll),
    .memSel(memSel), .desktopMode(desktopMode), .periph24(periph24)
  );

  // behavioural reference, updated at each rising edge
  int  mStrap = 0, mCode = 0, mPads = 0;
  bit  mLive = 0, mHad = 0, mValid = 0, mResolved = 0, mOvr = 0;
  bit  mSd = 0, mSe = 0, mTri = 0, mMem = 0, mDesk = 0, mPer = 0;

  always @(posedge clk) begin
    int eff;
    if (!porN) begin
      mStrap = strapPins; mPads = 0; mLive = 0; mHad = 0; mValid = 0;
      mCode = 0; mSd = 0; mSe = 0; mTri = 0; mMem = 0; mDesk = 0; mPer = 0;
      mResolved = 0;
    end else begin
      if (mLive) begin
        mOvr = cfgByte[3];
        if (cfgByte[3]) eff = cfgByte[2]*8 + cfgByte[6]*4 + cfgByte[5]*2 + cfgByte[4];
        else            eff = ((mStrap >> 3) & 1)*8 + (mStrap & 7);
        mValid = (!mHad) || (eff != mCode);
        mHad = 1; mCode = eff; mResolved = 1;
        mSd = cfgByte[7]; mSe = cfgByte[1]; mTri = cfgByte[0];
        mMem = (mStrap >> 3) & 1; mPer = (mStrap >> 4) & 1; mDesk = (mStrap >> 5) & 1;
      end else mValid = 0;
      mLive = 1; mPads = 63;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(mPads == 0 ? "R1 padOutEn" : "R2 padOutEn", padOutEn, mPads);
      chk(!mResolved ? "R9 freqCode" : (mOvr ? "R5 freqCode" : "R4 freqCode"), freqCode, mCode);
      chk("R8 codeValid", codeValid, mValid);
      chk("R6 spreadDown", spreadDown, mSd);
      chk("R6 spreadEn", spreadEn, mSe);
      chk("R6 tristateAll", tristateAll, mTri);
      chk("R7 memSel", memSel, mMem);
      chk("R7 periph24", periph24, mPer);
      chk("R7 desktopMode", desktopMode, mDesk);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(posedge clk);
    @(negedge clk);
    started = 1'b1;
    // R1 R9: in reset, pins change; last level must win
    cyc(3);
    chk("R1 pads input", padOutEn, 0);
    chk("R9 quiet", {freqCode, codeValid, memSel, periph24}, 0);
    strapPins = 6'h2A;
    cyc(2);
    porN = 1'b1;
    cyc(1);
    chk("R2 pads output", padOutEn, 63);
    cyc(1);
    chk("R4 hw code", freqCode, 4'hA);
    chk("R8 first strobe", codeValid, 1);
    chk("R7 desktop", desktopMode, 1);
    // R3: pin activity after release ignored
    for (int k = 0; k < 6; k++) begin
      strapPins = 6'(k * 11);
      cyc(1);
    end
    chk("R3 memSel frozen", memSel, 1);
    chk("R3 periph frozen", periph24, 0);
    chk("R3 code frozen", freqCode, 4'hA);
    chk("R8 no strobe held", codeValid, 0);
    // R5 R6: sweep override codes
    for (int i = 0; i < 16; i++) begin
      cfgByte = {i[0] ^ i[1], i[2], i[1], i[0], 1'b1, i[3], i[2], i[3]};
      cyc(1 + (i % 3));
    end
    cyc(1);
    chk("R5 override code", freqCode, 15);
    cfgByte = 8'h00;
    cyc(2);
    chk("R4 back to straps", freqCode, 4'hA);
    cfgByte = 8'h83;
    cyc(2);
    chk("R6 spread down", spreadDown, 1);
    chk("R6 tristate", tristateAll, 1);
    // second power-on with new straps
    porN = 1'b0;
    strapPins = 6'h13;
    cyc(3);
    chk("R9 quiet again", freqCode, 0);
    porN = 1'b1;
    cyc(2);
    chk("R7 periph24", periph24, 1);
    chk("R4 new code", freqCode, 4'h3);
    chk("R8 strobe after re-reset", codeValid, 1);
    cfgByte = 8'h78;
    cyc(2);
    chk("R5 code 7", freqCode, 7);
    cyc(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule